// File: doc/BRIEF.md
# Serial Lane Test Pattern Source

This block chooses the 10-bit word that one serial video lane sends on each clock. It can send a constant zero word, pass the lane's normal encoded data through, send a pseudo-random bit sequence, or play back a programmed 80-bit pattern. It is meant for link bring-up and bit-error measurement. Software sets the configuration fields, and the serialiser that follows sees a normal stream of 10-bit characters.

The pseudo-random source is one 31-bit history register. A selectable feedback pair gives it one of four maximal-length polynomials. Each clock it steps by 1, 8 or 10 bits and shows the bits it has just produced. The pattern source plays eight 10-bit words in a fixed order. It holds each word for a programmable number of clocks and wraps round after the last word. Each source has its own enable. The output is a register, so every choice reaches the lane one clock after the inputs that decided it.

Top module: `tmds_pattern_gen`

## Requirements
- R1: laneOut is one clock behind its inputs. When outSel is 3'b000, or any code other than 3'b001, 3'b010 or 3'b100, the following laneOut is 0.
- R2: When outSel is 3'b001, the following laneOut equals the normalData presented at that edge.
- R3: When prbsEn is 1 and prbsWidth is not 0, the random history steps on every clock, whatever outSel is. The feedback pair depends on prbsMode. Code 0 takes taps 11 and 9. Code 1 takes 15 and 14. Code 2 takes 7 and 6. Code 3 takes 31 and 28. Each new bit is the XOR of the two tapped history bits, and it enters at bit 0. The seed is all ones. With outSel 3'b010, laneOut shows the newest bits, and the newest bit is at bit 0.
- R4: prbsWidth selects the width. Code 3 steps 10 bits and drives laneOut[9:0]. Code 1 steps 8 bits and drives laneOut[7:0], with [9:8] at zero. Code 2 steps 1 bit and drives laneOut[0] only. Code 0 is idle: the history holds and the random word is 0.
- R5: While prbsEn is 0 the random word is 0 and the history is reloaded with the seed.
- R6: The pattern words are played in this order: shiftPattern[79:70] first, then each lower 10-bit slice, ending with [9:0]. After the last word the sequence returns to the first. With outSel 3'b100, the current word appears on laneOut.
- R7: With shiftRepeat equal to N, each pattern word is shown for N+1 consecutive clocks.
- R8: While shiftEn is 0 the pattern word is 0 and the sequence returns to the first word. After shiftEn is raised again, that word is shown first.
- R9: While rstN is low, laneOut is 0, the random history is back at the seed and the pattern sequence is at its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| outSel | input | 3 | Lane source select (one-hot; 0 or an invalid code gives zero) |
| normalData | input | 10 | Encoded character from the normal data path |
| prbsEn | input | 1 | Enable for the pseudo-random source |
| prbsMode | input | 2 | Polynomial choice for the random source |
| prbsWidth | input | 2 | Bits per clock for the random source (idle, 8, 1, 10) |
| shiftEn | input | 1 | Enable for the pattern playback source |
| shiftRepeat | input | 3 | Number of extra clocks each pattern word is held |
| shiftPattern | input | 80 | Eight 10-bit pattern words, first word in the top bits |
| laneOut | output | 10 | Character sent to the lane serialiser |

## Verification
The history register is not visible at the ports. A wrong feedback tap or a wrong step count changes only some later random words. It can take several words to show on laneOut, and for the longer polynomials it shows only after the seed's ones have moved through the tapped positions. Each mode is therefore run for dozens of clocks after a reseed. An error in the word index or the hold counter shows within one word period, as a slice presented in the wrong clock. The repeat counts are taken up to the largest hold, and the pattern is wrapped and restarted.

// File: rtl/tmds_pg_pkg.sv
package tmds_pg_pkg;
  localparam int LANE_W    = 10;
  localparam int PAT_WORDS = 8;
  localparam int PAT_W     = LANE_W * PAT_WORDS;
  localparam int HIST_W    = 31;
  localparam int RPT_W     = 3;
  localparam int IDX_W     = $clog2(PAT_WORDS);
  localparam int STEP_W    = $clog2(LANE_W + 1);
  localparam int TAP_W     = $clog2(HIST_W + 1);

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_NORMAL,
    SRC_PRBS,
    SRC_SHIFT
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              prbsReload;
    logic              prbsAdvance;
    logic [STEP_W-1:0] prbsSteps;
    logic [LANE_W-1:0] prbsMask;
    logic [TAP_W-1:0]  tapLen;
    logic [TAP_W-1:0]  tapMid;
    logic [IDX_W-1:0]  wordIdx;
    srcSel_e           src;
  } pgStrobe_t;
endpackage

// File: rtl/tmds_pg_ctrl.sv
module tmds_pg_ctrl
  import tmds_pg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       outSel,
  input  logic             prbsEn,
  input  logic [1:0]       prbsMode,
  input  logic [1:0]       prbsWidth,
  input  logic             shiftEn,
  input  logic [RPT_W-1:0] shiftRepeat,
  output pgStrobe_t        strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_WORDS - 1);

  logic [IDX_W-1:0] wordIdx;
  logic [RPT_W-1:0] holdCnt;

  // pattern sequencer: hold counter and word index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      holdCnt <= '0;
    end else if (!shiftEn) begin
      wordIdx <= '0;
      holdCnt <= '0;
    end else if (holdCnt >= shiftRepeat) begin
      holdCnt <= '0;
      wordIdx <= (wordIdx == LAST_IDX) ? '0 : wordIdx + 1'b1;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    strb             = '0;
    strb.prbsReload  = !prbsEn;
    strb.prbsAdvance = prbsEn && (prbsWidth != 2'd0);
    strb.wordIdx     = wordIdx;

    unique case (prbsWidth)
      2'd1:    begin strb.prbsSteps = STEP_W'(8);      strb.prbsMask = LANE_W'(8'hFF); end
      2'd2:    begin strb.prbsSteps = STEP_W'(1);      strb.prbsMask = LANE_W'(1);     end
      2'd3:    begin strb.prbsSteps = STEP_W'(LANE_W); strb.prbsMask = '1;             end
      default: begin strb.prbsSteps = '0;              strb.prbsMask = '0;             end
    endcase

    unique case (prbsMode)
      2'd0:    begin strb.tapLen = TAP_W'(11); strb.tapMid = TAP_W'(9);  end
      2'd1:    begin strb.tapLen = TAP_W'(15); strb.tapMid = TAP_W'(14); end
      2'd2:    begin strb.tapLen = TAP_W'(7);  strb.tapMid = TAP_W'(6);  end
      default: begin strb.tapLen = TAP_W'(31); strb.tapMid = TAP_W'(28); end
    endcase

    case (outSel)
      3'b001:  strb.src = SRC_NORMAL;
      3'b010:  strb.src = SRC_PRBS;
      3'b100:  strb.src = shiftEn ? SRC_SHIFT : SRC_ZERO;
      default: strb.src = SRC_ZERO;
    endcase
  end
endmodule

// File: rtl/tmds_pg_data.sv
module tmds_pg_data
  import tmds_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         strb,
  input  logic [LANE_W-1:0] normalData,
  input  logic [PAT_W-1:0]  shiftPattern,
  output logic [LANE_W-1:0] laneOut
);
  localparam logic [HIST_W-1:0] SEED = '1;

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] stepped;
  logic [HIST_W-1:0] histNext;
  logic [LANE_W-1:0] prbsWord;
  logic [LANE_W-1:0] shiftWord;
  logic [LANE_W-1:0] wordNext;
  logic [LANE_W-1:0] shiftWords [PAT_WORDS];

  function automatic logic [HIST_W-1:0] runLfsr(
    input logic [HIST_W-1:0] start,
    input logic [STEP_W-1:0] steps,
    input logic [TAP_W-1:0]  len,
    input logic [TAP_W-1:0]  mid
  );
    logic [HIST_W-1:0] h;
    logic fb;
    h = start;
    for (int i = 0; i < LANE_W; i++) begin
      if (i < int'(steps)) begin
        fb = h[len - 1'b1] ^ h[mid - 1'b1];
        h  = {h[HIST_W-2:0], fb};
      end
    end
    return h;
  endfunction

  // slice the pattern, first word in the top bits
  for (genvar g = 0; g < PAT_WORDS; g++) begin : g_slice
    assign shiftWords[g] = shiftPattern[PAT_W-1-g*LANE_W -: LANE_W];
  end

  always_comb begin
    stepped   = runLfsr(hist, strb.prbsSteps, strb.tapLen, strb.tapMid);
    histNext  = strb.prbsReload ? SEED : (strb.prbsAdvance ? stepped : hist);
    prbsWord  = strb.prbsAdvance ? (stepped[LANE_W-1:0] & strb.prbsMask) : '0;
    shiftWord = shiftWords[strb.wordIdx];
    unique case (strb.src)
      SRC_NORMAL: wordNext = normalData;
      SRC_PRBS:   wordNext = prbsWord;
      SRC_SHIFT:  wordNext = shiftWord;
      default:    wordNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= SEED;
      laneOut <= '0;
    end else begin
      hist    <= histNext;
      laneOut <= wordNext;
    end
  end
endmodule

// File: rtl/tmds_pattern_gen.sv
module tmds_pattern_gen
  import tmds_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        outSel,
  input  logic [LANE_W-1:0] normalData,
  input  logic              prbsEn,
  input  logic [1:0]        prbsMode,
  input  logic [1:0]        prbsWidth,
  input  logic              shiftEn,
  input  logic [RPT_W-1:0]  shiftRepeat,
  input  logic [PAT_W-1:0]  shiftPattern,
  output logic [LANE_W-1:0] laneOut
);
  pgStrobe_t strb;

  tmds_pg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .outSel      (outSel),
    .prbsEn      (prbsEn),
    .prbsMode    (prbsMode),
    .prbsWidth   (prbsWidth),
    .shiftEn     (shiftEn),
    .shiftRepeat (shiftRepeat),
    .strb        (strb)
  );

  tmds_pg_data u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .normalData   (normalData),
    .shiftPattern (shiftPattern),
    .laneOut      (laneOut)
  );
endmodule

// File: rtl/tmds_pg_checker.sv
module tmds_pg_checker
  import tmds_pg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        outSel,
  input logic [LANE_W-1:0] normalData,
  input logic              prbsEn,
  input logic [1:0]        prbsWidth,
  input logic              shiftEn,
  input logic [LANE_W-1:0] laneOut
);
  // R1: zero or undefined select gives a zero word next clock
  a_r1_zero_select: assert property (@(posedge clk) disable iff (!rstN)
    !(outSel == 3'b001 || outSel == 3'b010 || outSel == 3'b100) |=> laneOut == '0);

  // R2: pass-through is one clock late
  a_r2_normal_pass: assert property (@(posedge clk) disable iff (!rstN)
    outSel == 3'b001 |=> laneOut == $past(normalData));

  // R4: 8-bit width keeps the top two bits clear
  a_r4_width8_top: assert property (@(posedge clk) disable iff (!rstN)
    (outSel == 3'b010 && prbsWidth == 2'd1) |=> laneOut[LANE_W-1:8] == '0);

  // R4: 1-bit width drives bit 0 only
  a_r4_width1_only: assert property (@(posedge clk) disable iff (!rstN)
    (outSel == 3'b010 && prbsWidth == 2'd2) |=> laneOut[LANE_W-1:1] == '0);

  // R4: idle width gives zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outSel == 3'b010 && prbsWidth == 2'd0) |=> laneOut == '0);

  // R5: disabled random source gives zero
  a_r5_prbs_off: assert property (@(posedge clk) disable iff (!rstN)
    (outSel == 3'b010 && !prbsEn) |=> laneOut == '0);

  // R8: disabled pattern source gives zero
  a_r8_shift_off: assert property (@(posedge clk) disable iff (!rstN)
    (outSel == 3'b100 && !shiftEn) |=> laneOut == '0);

  // R9: output cleared while reset is held
  always @(posedge clk) begin
    if (!rstN) a_r9_reset_zero: assert (laneOut == '0);
  end
endmodule

bind tmds_pattern_gen tmds_pg_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .outSel     (outSel),
  .normalData (normalData),
  .prbsEn     (prbsEn),
  .prbsWidth  (prbsWidth),
  .shiftEn    (shiftEn),
  .laneOut    (laneOut)
);

// File: tb/tmds_pattern_gen_bench.sv
`timescale 1ns/1ps
module tmds_pattern_gen_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  outSel;
  logic [9:0]  normalData;
  logic        prbsEn;
  logic [1:0]  prbsMode;
  logic [1:0]  prbsWidth;
  logic        shiftEn;
  logic [2:0]  shiftRepeat;
  logic [79:0] shiftPattern;
  logic [9:0]  laneOut;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit finished = 0;
  string phaseTag = "R9";

  // reference model state
  logic [30:0] mHist;
  int mPos, mHold;
  logic [9:0] expOut;

  always #2.5 clk = ~clk;

  tmds_pattern_gen u_tmds_pattern_gen (
    .clk(clk), .rstN(rstN), .outSel(outSel), .normalData(normalData),
    .prbsEn(prbsEn), .prbsMode(prbsMode), .prbsWidth(prbsWidth),
    .shiftEn(shiftEn), .shiftRepeat(shiftRepeat),
    .shiftPattern(shiftPattern), .laneOut(laneOut)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    logic [9:0] pw, sw;
    int len, mid, nSteps;
    logic [9:0] mask;
    logic fb;
    started = 1;
    if (!rstN) begin
      mHist = '1; mPos = 0; mHold = 0; expOut = '0;
    end else begin
      pw = '0;
      if (!prbsEn) mHist = '1;
      else if (prbsWidth != 0) begin
        case (prbsMode)
          0: begin len = 11; mid = 9;  end
          1: begin len = 15; mid = 14; end
          2: begin len = 7;  mid = 6;  end
          default: begin len = 31; mid = 28; end
        endcase
        case (prbsWidth)
          1: begin nSteps = 8;  mask = 10'h0FF; end
          2: begin nSteps = 1;  mask = 10'h001; end
          default: begin nSteps = 10; mask = 10'h3FF; end
        endcase
        for (int k = 0; k < nSteps; k++) begin
          fb = mHist[len-1] ^ mHist[mid-1];
          mHist = {mHist[29:0], fb};
        end
        pw = mHist[9:0] & mask;
      end
      sw = '0;
      if (!shiftEn) begin mPos = 0; mHold = 0; end
      else begin
        sw = shiftPattern[79 - 10*mPos -: 10];
        if (mHold >= int'(shiftRepeat)) begin mHold = 0; mPos = (mPos + 1) % 8; end
        else mHold = mHold + 1;
      end
      case (outSel)
        3'b001: expOut = normalData;
        3'b010: expOut = pw;
        3'b100: expOut = sw;
        default: expOut = '0;
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (laneOut !== expOut) begin
        failures++;
        $display("FAIL %s laneOut actual=%h expected=%h at %0t", phaseTag, laneOut, expOut, $time);
      end
    end
  end

  task automatic run(input int n, input bit randData);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (randData) normalData = 10'($urandom);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    rstN = 0; outSel = 0; normalData = 0; prbsEn = 0; prbsMode = 0;
    prbsWidth = 0; shiftEn = 0; shiftRepeat = 0; shiftPattern = '0;
    phaseTag = "R9";
    run(4, 1);
    rstN = 1;

    phaseTag = "R2"; outSel = 3'b001;
    run(20, 1);

    // R1: zero and undefined codes, random source running behind
    phaseTag = "R1"; prbsEn = 1; prbsWidth = 3;
    foreach (outSel[i]) ;
    outSel = 3'b000; run(3, 1);
    outSel = 3'b011; run(3, 1);
    outSel = 3'b101; run(3, 1);
    outSel = 3'b110; run(3, 1);
    outSel = 3'b111; run(3, 1);

    // R3: each polynomial from a fresh seed, 10-bit width
    outSel = 3'b010;
    for (int m = 0; m < 4; m++) begin
      phaseTag = "R5"; prbsEn = 0; run(1, 0);
      phaseTag = "R3"; prbsEn = 1; prbsMode = 2'(m); prbsWidth = 3; run(40, 0);
    end

    // R3: history keeps stepping while another source is shown
    outSel = 3'b001; phaseTag = "R3"; run(7, 1);
    outSel = 3'b010; run(10, 0);

    // R4: widths and idle
    phaseTag = "R4"; prbsMode = 0;
    prbsWidth = 1; run(20, 0);
    prbsWidth = 2; run(20, 0);
    prbsWidth = 0; run(5, 0);
    prbsWidth = 3; run(10, 0);
    prbsMode = 2; prbsWidth = 1; run(15, 0);

    // R5: disabled random source
    phaseTag = "R5"; prbsEn = 0; prbsWidth = 3; run(5, 0);
    prbsEn = 1; prbsMode = 1; run(10, 0);

    // R6/R7/R8: pattern playback
    shiftPattern = {16'($urandom), 32'($urandom), 32'($urandom)};
    outSel = 3'b100;
    phaseTag = "R8"; shiftEn = 0; run(3, 0);
    phaseTag = "R6"; shiftEn = 1; shiftRepeat = 0; run(20, 0);
    phaseTag = "R7"; shiftRepeat = 3; run(40, 0);
    shiftRepeat = 7; run(70, 0);
    phaseTag = "R8"; shiftEn = 0; run(5, 0);
    shiftEn = 1; shiftRepeat = 1; run(20, 0);
    phaseTag = "R7"; shiftRepeat = 7; run(5, 0);
    shiftRepeat = 2; run(30, 0);

    // R9: reset mid-run
    phaseTag = "R9"; rstN = 0; run(3, 0);
    rstN = 1; phaseTag = "R6"; run(12, 0);

    report();
  end
endmodule